// File: doc/BRIEF.md
# Rotary Encoder Delay Stepper

This block turns detent steps of a two-pin rotary encoder into a coarse delay setting for a sample-based audio delay line. The encoder pins arrive already debounced. The block looks at them only on every 64th frame tick, and it counts a step only when pin A falls. Each step moves the high byte of a 16-bit desired delay by one. One unit of that byte is 256 samples, which is about 6 ms at audio rates. The low byte is always zero.

Pin B, read on the same sampling tick as the falling edge, sets the direction. The delay high byte wraps like an 8-bit register. The same sampling tick also captures a four-bit program-select switch field from an 8-bit switch port and turns it into a selector value. The block does nothing else with the selector.

Top module: `encoder_delay_stepper`

## Requirements
- R1: After reset, `delayOut` is 0x0000 and `selOut` is 0x00.
- R2: A sampling tick is the first `frameTick` after reset and then every 64th `frameTick` after that. Cycles with `frameTick` low change no output and do not advance the sampling schedule.
- R3: When pin A reads high on a sampling tick, no step is counted and the edge-seen state is cleared.
- R4: When pin A reads low on a sampling tick and the previous sampling tick saw pin A high (or none has occurred since reset), exactly one step is counted. Further sampling ticks with pin A still low count nothing.
- R5: On a counted step, pin B high decrements the delay high byte (`delayOut[15:8]`) by one, and pin B low increments it by one.
- R6: `delayOut[7:0]` is always zero, so each step changes `delayOut` by 256.
- R7: The delay high byte wraps modulo 256: 0xFF plus one gives 0x00, and 0x00 minus one gives 0xFF.
- R8: On every sampling tick, `selOut` becomes `((swIn & 0x78) >> 2) + 2`. The values of `swIn` between sampling ticks are ignored.
- R9: Encoder pin changes between sampling ticks are ignored. A low pulse on pin A that does not cover a sampling tick counts no step.
- R10: Outputs take their new values on the clock edge where the sampling tick is seen, and they hold until the next sampling tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | One-cycle pulse per audio frame |
| encA | input | 1 | Encoder pin A (debounced); a falling edge marks a step |
| encB | input | 1 | Encoder pin B (debounced); gives the direction |
| swIn | input | 8 | Switch port; bits 6..3 hold the program-select field |
| delayOut | output | 16 | Desired delay in samples; low byte is zero |
| selOut | output | 8 | Captured program selector value |

## Verification
On every cycle, the assertions check these behaviours: the delay and selector stay still outside sampling ticks, the schedule counter freezes without a frame tick, each counted step moves the high byte by exactly one in the direction pin B gives (with wrap), and the edge-seen state follows pin A. Some behaviours only the bench's scenarios can show. These are the 64-tick spacing of the sampling ticks measured from reset, that a held low level or a short low pulse between samples counts nothing, that long runs of steps wrap through both ends of the byte, and the exact selector arithmetic across random switch patterns.

// File: rtl/encdly_pkg.sv
package encdly_pkg;
  // Strobes from control to datapath, valid in the cycle of a sampling tick
  typedef struct packed {
    logic sample;
    logic stepUp;
    logic stepDn;
  } encStrobe_t;
endpackage

// File: rtl/encdly_ctrl.sv
module encdly_ctrl
  import encdly_pkg::*;
#(
  parameter int RELOAD = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameTick,
  input  logic       encA,
  input  logic       encB,
  output encStrobe_t strb
);
  localparam int CNT_W = $clog2(RELOAD + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(RELOAD - 1);

  logic [CNT_W-1:0] cnt;
  logic             edgeSeen;
  logic             newFall;

  // A sample happens on a tick when the schedule counter is exhausted
  always_comb begin
    strb.sample = frameTick && (cnt == '0);
    newFall     = strb.sample && !encA && !edgeSeen;
    strb.stepUp = newFall && !encB;
    strb.stepDn = newFall && encB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      edgeSeen <= 1'b0;
    end else if (frameTick) begin
      if (cnt == '0) cnt <= CNT_TOP;
      else           cnt <= cnt - 1'b1;
      if (strb.sample) begin
        if (encA) edgeSeen <= 1'b0;
        else      edgeSeen <= 1'b1;
      end
    end
  end

  // R2: schedule freezes when no frame tick arrives
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(cnt));
  // R3: pin A high at a sample clears the edge state
  p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sample && encA) |=> !edgeSeen);
  // R4: a counted step leaves the edge state set, blocking repeats
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepUp || strb.stepDn) |=> edgeSeen);
  // R4: never both directions at once
  p_one_dir_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.stepUp, strb.stepDn}));
endmodule

// File: rtl/encdly_dp.sv
module encdly_dp
  import encdly_pkg::*;
#(
  parameter int HI_W      = 8,
  parameter int LO_W      = 8,
  parameter int SW_W      = 8,
  parameter int SEL_LSB   = 3,
  parameter int SEL_BITS  = 4,
  parameter int SEL_SHIFT = 2,
  parameter int SEL_OFS   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  encStrobe_t           strb,
  input  logic [SW_W-1:0]      swIn,
  output logic [HI_W+LO_W-1:0] delayOut,
  output logic [SW_W-1:0]      selOut
);
  localparam int KEEP = SEL_LSB - SEL_SHIFT;

  logic [HI_W-1:0]     delayHi;
  logic [SW_W-1:0]     selReg;
  logic [SEL_BITS-1:0] field;
  logic [SW_W-1:0]     selNext;

  always_comb begin
    field   = swIn[SEL_LSB +: SEL_BITS];
    selNext = (SW_W'(field) << KEEP) + SW_W'(SEL_OFS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayHi <= '0;
      selReg  <= '0;
    end else if (strb.sample) begin
      selReg <= selNext;
      if (strb.stepUp)      delayHi <= delayHi + 1'b1;
      else if (strb.stepDn) delayHi <= delayHi - 1'b1;
    end
  end

  assign delayOut = {delayHi, {LO_W{1'b0}}};
  assign selOut   = selReg;

  // R2: outputs hold between sampling ticks
  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sample |=> ($stable(delayHi) && $stable(selReg)));
  // R5 R7: an up step adds one modulo the byte
  p_step_up_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepUp |=> (delayHi == HI_W'($past(delayHi) + 1'b1)));
  // R5 R7: a down step subtracts one modulo the byte
  p_step_dn_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepDn |=> (delayHi == HI_W'($past(delayHi) - 1'b1)));
  // R8: a captured selector never falls below the offset
  p_sel_floor_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample |=> (selReg >= SW_W'(SEL_OFS)));
endmodule

// File: rtl/encoder_delay_stepper.sv
module encoder_delay_stepper
  import encdly_pkg::*;
#(
  parameter int RELOAD = 64,
  parameter int HI_W   = 8,
  parameter int LO_W   = 8,
  parameter int SW_W   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameTick,
  input  logic                 encA,
  input  logic                 encB,
  input  logic [SW_W-1:0]      swIn,
  output logic [HI_W+LO_W-1:0] delayOut,
  output logic [SW_W-1:0]      selOut
);
  encStrobe_t strb;

  encdly_ctrl #(.RELOAD(RELOAD)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameTick(frameTick),
    .encA(encA), .encB(encB), .strb(strb)
  );

  encdly_dp #(.HI_W(HI_W), .LO_W(LO_W), .SW_W(SW_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .swIn(swIn),
    .delayOut(delayOut), .selOut(selOut)
  );
endmodule

// File: tb/sim_encoder_delay_stepper.sv
module sim_encoder_delay_stepper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameTick = 1'b0;
  logic        encA = 1'b1;
  logic        encB = 1'b0;
  logic [7:0]  swIn = 8'h00;
  logic [15:0] delayOut;
  logic [7:0]  selOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model
  int        schedCnt = 0;
  bit        mFlag = 0;
  logic [7:0] mHi = 8'h00;
  logic [7:0] mSel = 8'h00;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;  // 250 MHz

  encoder_delay_stepper u0 (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .encA(encA),
    .encB(encB), .swIn(swIn), .delayOut(delayOut), .selOut(selOut)
  );

  task automatic compare(input string tag);
    checks++;
    if (delayOut !== {mHi, 8'h00}) begin
      errors++;
      $display("FAIL %s delay got %h exp %h", tag, delayOut, {mHi, 8'h00});
    end
    checks++;
    if (selOut !== mSel) begin
      errors++;
      $display("FAIL %s R8 sel got %h exp %h", tag, selOut, mSel);
    end
  endtask

  // one frame tick; called at a negedge, returns at the next negedge
  task automatic tick(input logic a, input logic b, input logic [7:0] sw, input string tag);
    encA = a; encB = b; swIn = sw; frameTick = 1'b1;
    @(posedge clk);
    if (schedCnt == 0) begin
      schedCnt = 63;
      mSel = ((sw & 8'h78) >> 2) + 8'd2;
      if (a) mFlag = 0;
      else if (!mFlag) begin
        mFlag = 1;
        if (b) mHi = mHi - 8'd1; else mHi = mHi + 8'd1;
      end
    end else schedCnt--;
    @(negedge clk);
    frameTick = 1'b0;
    compare(tag);
  endtask

  // one sampling period: sample tick with (a,b), then 63 ticks of noise (R9)
  task automatic period(input logic a, input logic b, input string tag);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tick(a, b, lfsr[7:0], tag);
    for (int i = 0; i < 63; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(~a, ~b, lfsr[7:0], {tag, " R9"});
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1");

    // R3 R4 R5: first sample with A high, then a fall, then A held low (no recount)
    period(1'b1, 1'b0, "R3");
    period(1'b0, 1'b0, "R4 R5");
    period(1'b0, 1'b0, "R4 held");
    period(1'b0, 1'b1, "R4 held B");

    // R2 R10: idle cycles with moving inputs change nothing, schedule frozen
    for (int i = 0; i < 40; i++) begin
      encA = i[0]; encB = i[1]; swIn = 8'(i * 37);
      @(negedge clk);
      compare("R2 idle");
    end

    // R5 R7: right turns past 0xFF
    for (int p = 0; p < 520; p++) period(p[0] ? 1'b0 : 1'b1, 1'b0, "R5 R6 R7 up");
    // R5 R7: left turns below 0x00
    for (int p = 0; p < 560; p++) period(p[0] ? 1'b0 : 1'b1, 1'b1, "R5 R6 R7 down");
    // R2 R4 R8: random encoder patterns
    for (int p = 0; p < 400; p++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      period(lfsr[3], lfsr[9], "R2 R4 R8 rand");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule